// File: doc/BRIEF.md
# Priority Interrupt Controller

This block gathers interrupt requests from a set of peripheral sources and a few fixed core-side sources. It decides which pending request the processor core should service next, and shows the core that request's vector number, priority level and handler address. Software programs each peripheral source through a small write port. A source gets one of three ordinary priority levels and an enable bit. The write port also sets the base of the vector table and maps one source to a single fast-interrupt slot. The fast slot has its own handler address.

Requests are ordered in five tiers: a lowest software tier, three ordinary tiers, and a top tier. The top tier has two groups. One group ignores the core's mask. The other, a debug group, obeys the mask. The core supplies its current priority mask, and a request is offered only when its level is above that mask. This is how nesting works. The core takes a request by acknowledging the presented vector, which removes it from the pending set. Whenever anything enabled is pending, the block raises a wake request to the clock controller.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, no request is presented (`req_o`=0, `fast_o`=0), `wake_o` is 0, and every peripheral source is disabled.
- R2: A write with kind 0 sets peripheral `wr_idx`. Its priority code comes from `wr_data[1:0]`: 0, 1 or 2 for ordinary tiers 0 to 2. Its enable comes from `wr_data[2]`. A kind-0 write carrying priority code 3 changes nothing.
- R3: `lvl_o` encodes levels as: software tier 1, ordinary tier 0/1/2 as 2/3/4, top tier (both groups) 5.
- R4: Vector numbers run as follows: unmaskable sources `exc_i[0..3]` are 0..3, debug sources `dbg_i[0..2]` are 4..6, the software source is 7, and peripheral k is 8+k. The highest level wins, and among equal levels the lowest vector number wins.
- R5: Each request except vectors 0..3 is offered only when its level exceeds `core_mask_i`. Vectors 0..3 are offered whatever the mask.
- R6: Kind 1 maps peripheral `wr_idx` into the fast slot, with `wr_data` as its handler address. Kind 2 unmaps it. A qualifying fast source beats all ordinary and software-tier requests. When it does, `fast_o`=1 and `addr_o` is the fast address. Any qualifying top-tier request still beats it.
- R7: Kind 3 loads the vector base from `wr_data`. Outside the fast path, `addr_o` = base + 2 × vector number.
- R8: A request seen on an enabled source stays pending until acknowledged. `ack_i` while `req_o`=1 clears the presented vector at that clock edge. An input still high pends again one cycle later.
- R9: A disabled peripheral's input is not latched, is never presented and does not raise `wake_o`.
- R10: `wake_o` is 1 whenever any enabled request is pending, even if the mask blocks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_i | input | 4 | Unmaskable top-tier requests |
| dbg_i | input | 3 | Maskable top-tier (debug) requests |
| swlp_i | input | 1 | Lowest-tier software request |
| irq_i | input | NSRC | Peripheral requests |
| wr_en | input | 1 | Configuration write strobe |
| wr_kind | input | 2 | Write kind: 0 source, 1 fast map, 2 fast off, 3 base |
| wr_idx | input | SRC_W | Peripheral index for the write |
| wr_data | input | ADDR_W | Write data |
| core_mask_i | input | 3 | Level the core is currently running at |
| ack_i | input | 1 | Core takes the presented vector |
| req_o | output | 1 | A request is presented |
| vec_id_o | output | ID_W | Presented vector number |
| lvl_o | output | 3 | Presented level |
| addr_o | output | ADDR_W | Handler address |
| fast_o | output | 1 | Presented request uses the fast slot |
| wake_o | output | 1 | Wake request to the clock controller |

## Verification
The hardest situation to reach is the gap of one cycle after an acknowledge while the peripheral input is still high. The bench holds the input, acknowledges, and then samples on each of the next two cycles to see the drop and the re-pend. Another hard case is the fast slot losing to a top-tier request and then winning again. The bench gets there by pulsing a debug request while the fast source is pending, acknowledging it, and then unmapping the slot. A table of pairs of peripheral sources at different levels and masks covers the ordering and tie rules.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int N_FIXED  = 8;
    localparam int UNM_LAST = 3;
    localparam int LP_ID    = 7;
    localparam logic [2:0] LV_LP  = 3'd1;
    localparam logic [2:0] LV_ORD = 3'd2;
    localparam logic [2:0] LV_TOP = 3'd5;

    typedef enum logic [1:0] {
        WR_SRC      = 2'd0,
        WR_FAST_MAP = 2'd1,
        WR_FAST_OFF = 2'd2,
        WR_BASE     = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/pic_pend.sv
module pic_pend #(
    parameter int N_ID = 72,
    parameter int ID_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_ID-1:0] set_i,
    input  logic            clr_en_i,
    input  logic [ID_W-1:0] clr_id_i,
    output logic [N_ID-1:0] pend_o
);
    typedef struct packed {
        logic [N_ID-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = st_q.pend | set_i;
        if (clr_en_i && (32'(clr_id_i) < N_ID)) begin
            st_d.pend[clr_id_i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R8: acknowledged vector is not pending right after the ack edge
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && (32'(clr_id_i) < N_ID)) |=> !pend_o[$past(clr_id_i)]);
endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
    parameter int N_ID = 72,
    parameter int ID_W = 7
) (
    input  logic [N_ID-1:0]      cand_i,
    input  logic [N_ID-1:0][2:0] rank_i,
    output logic                 found_o,
    output logic [ID_W-1:0]      id_o,
    output logic [2:0]           rank_o
);
    always_comb begin
        found_o = 1'b0;
        id_o    = '0;
        rank_o  = '0;
        for (int k = N_ID - 1; k >= 0; k--) begin
            if (cand_i[k] && (!found_o || rank_i[k] >= rank_o)) begin
                found_o = 1'b1;
                id_o    = ID_W'(k);
                rank_o  = rank_i[k];
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import pic_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int ADDR_W = 16,
    localparam int N_ID  = NSRC + N_FIXED,
    localparam int ID_W  = $clog2(N_ID),
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        exc_i,
    input  logic [2:0]        dbg_i,
    input  logic              swlp_i,
    input  logic [NSRC-1:0]   irq_i,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [SRC_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [2:0]        core_mask_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic [ID_W-1:0]   vec_id_o,
    output logic [2:0]        lvl_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              fast_o,
    output logic              wake_o
);
    typedef struct packed {
        logic [NSRC-1:0][1:0] prio;
        logic [NSRC-1:0]      en;
        logic                 fast_en;
        logic [SRC_W-1:0]     fast_src;
        logic [ADDR_W-1:0]    fast_addr;
        logic [ADDR_W-1:0]    base;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && (32'(wr_idx) < NSRC)) begin
            case (wr_kind_e'(wr_kind))
                WR_SRC: begin
                    if (wr_data[1:0] != 2'd3) begin
                        cfg_d.prio[wr_idx] = wr_data[1:0];
                        cfg_d.en[wr_idx]   = wr_data[2];
                    end
                end
                WR_FAST_MAP: begin
                    cfg_d.fast_en   = 1'b1;
                    cfg_d.fast_src  = wr_idx;
                    cfg_d.fast_addr = wr_data;
                end
                WR_FAST_OFF: cfg_d.fast_en = 1'b0;
                default:     cfg_d.base    = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    logic [N_ID-1:0]      raw, en_all, pend, elig, cand;
    logic [N_ID-1:0][2:0] rank;
    logic                 win_found;
    logic [ID_W-1:0]      win_id, fast_id;
    logic [2:0]           win_rank;
    logic                 fast_take, top_any;

    assign raw    = {irq_i & cfg_q.en, swlp_i, dbg_i, exc_i};
    assign en_all = {cfg_q.en, {N_FIXED{1'b1}}};

    pic_pend #(.N_ID(N_ID), .ID_W(ID_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (raw),
        .clr_en_i (ack_i && req_o),
        .clr_id_i (vec_id_o),
        .pend_o   (pend)
    );

    assign elig = pend & en_all;

    for (genvar g = 0; g < N_ID; g++) begin : g_rank
        if (g < LP_ID) begin : g_top
            assign rank[g] = LV_TOP;
        end else if (g == LP_ID) begin : g_lp
            assign rank[g] = LV_LP;
        end else begin : g_ord
            assign rank[g] = LV_ORD + {1'b0, cfg_q.prio[g-N_FIXED]};
        end
        if (g <= UNM_LAST) begin : g_unm
            assign cand[g] = elig[g];
        end else begin : g_msk
            assign cand[g] = elig[g] && (rank[g] > core_mask_i);
        end
    end

    pic_arb #(.N_ID(N_ID), .ID_W(ID_W)) u_arb (
        .cand_i  (cand),
        .rank_i  (rank),
        .found_o (win_found),
        .id_o    (win_id),
        .rank_o  (win_rank)
    );

    assign fast_id   = ID_W'(32'(cfg_q.fast_src) + N_FIXED);
    assign top_any   = |cand[LP_ID-1:0];
    assign fast_take = cfg_q.fast_en && cand[fast_id] && !top_any;

    assign req_o    = win_found;
    assign fast_o   = fast_take;
    assign vec_id_o = fast_take ? fast_id : win_id;
    assign lvl_o    = fast_take ? rank[fast_id] : win_rank;
    assign addr_o   = fast_take ? cfg_q.fast_addr
                                : cfg_q.base + ADDR_W'({win_id, 1'b0});
    assign wake_o   = |elig;

    // R5: a maskable request is never offered at or below the core mask
    a_r5_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && vec_id_o > ID_W'(UNM_LAST)) |-> (lvl_o > core_mask_i));
    // R5: a pending unmaskable request is always the one offered
    a_r5_unmaskable_served: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend[UNM_LAST:0]) |-> (req_o && vec_id_o <= ID_W'(UNM_LAST)));
    // R10: anything offered implies a wake request
    a_r10_wake_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> wake_o);
    // R6: fast path only serves an ordinary-tier peripheral
    a_r6_fast_below_top: assert property (@(posedge clk) disable iff (!rst_n)
        fast_o |-> (req_o && lvl_o >= LV_ORD && lvl_o < LV_TOP));
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 64;

    logic        clk = 0, rst_n = 0;
    logic [3:0]  exc_i = 0;
    logic [2:0]  dbg_i = 0;
    logic        swlp_i = 0;
    logic [NSRC-1:0] irq_i = '0;
    logic        wr_en = 0;
    logic [1:0]  wr_kind = 0;
    logic [5:0]  wr_idx = 0;
    logic [15:0] wr_data = 0;
    logic [2:0]  core_mask_i = 0;
    logic        ack_i = 0;
    logic        req_o, fast_o, wake_o;
    logic [6:0]  vec_id_o;
    logic [2:0]  lvl_o;
    logic [15:0] addr_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .exc_i(exc_i), .dbg_i(dbg_i), .swlp_i(swlp_i),
        .irq_i(irq_i), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
        .wr_data(wr_data), .core_mask_i(core_mask_i), .ack_i(ack_i),
        .req_o(req_o), .vec_id_o(vec_id_o), .lvl_o(lvl_o), .addr_o(addr_o),
        .fast_o(fast_o), .wake_o(wake_o)
    );

    typedef struct packed {
        logic [5:0] a;  logic [1:0] pa;
        logic [5:0] b;  logic [1:0] pb;
        logic [2:0] mask;
        logic       req;
        logic [6:0] id;
        logic [2:0] lvl;
    } row_t;

    // R4 / R5 ordering table
    localparam row_t TBL [6] = '{
        '{6'd5,  2'd0, 6'd9, 2'd2, 3'd0, 1'b1, 7'd17, 3'd4},
        '{6'd5,  2'd1, 6'd9, 2'd1, 3'd0, 1'b1, 7'd13, 3'd3},
        '{6'd40, 2'd2, 6'd3, 2'd0, 3'd3, 1'b1, 7'd48, 3'd4},
        '{6'd10, 2'd1, 6'd11,2'd1, 3'd3, 1'b0, 7'd0,  3'd0},
        '{6'd63, 2'd0, 6'd0, 2'd0, 3'd1, 1'b1, 7'd8,  3'd2},
        '{6'd62, 2'd2, 6'd1, 2'd1, 3'd4, 1'b0, 7'd0,  3'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] k, input logic [5:0] idx, input logic [15:0] d);
        wr_en = 1; wr_kind = k; wr_idx = idx; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; exc_i = 0; dbg_i = 0; swlp_i = 0; irq_i = '0;
        ack_i = 0; core_mask_i = 0; wr_en = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    task automatic ack();
        ack_i = 1; tick(); ack_i = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 req", req_o, 0);
        chk("R1 wake", wake_o, 0);
        chk("R1 fast", fast_o, 0);

        // R9 disabled sources are ignored
        irq_i = '1; tick(); irq_i = '0; tick();
        chk("R9 req", req_o, 0);
        chk("R9 wake", wake_o, 0);

        // table walk: R4 ordering, R5 masking, R3 levels
        for (int i = 0; i < 6; i++) begin
            row_t r;
            r = TBL[i];
            do_reset();
            wr(2'd0, r.a, {13'd0, 1'b1, r.pa});
            wr(2'd0, r.b, {13'd0, 1'b1, r.pb});
            core_mask_i = r.mask;
            irq_i[r.a] = 1'b1; irq_i[r.b] = 1'b1;
            tick();
            chk("R5 table req", req_o, r.req);
            if (r.req) begin
                chk("R4 table id", vec_id_o, r.id);
                chk("R3 table lvl", lvl_o, r.lvl);
            end
            chk("R10 table wake", wake_o, 1);
            irq_i = '0;
        end

        // R2 / R7 / R8
        do_reset();
        wr(2'd3, 0, 16'h1000);
        wr(2'd0, 4, 16'h0005);
        wr(2'd0, 4, 16'h0003);
        irq_i[4] = 1; tick();
        chk("R2 code3 ignored req", req_o, 1);
        chk("R2 code3 ignored lvl", lvl_o, 3);
        chk("R4 id", vec_id_o, 12);
        chk("R7 addr", addr_o, 16'h1018);
        ack();
        chk("R8 cleared by ack", req_o, 0);
        tick();
        chk("R8 re-pend", req_o, 1);
        irq_i[4] = 0; tick();
        chk("R8 latched", req_o, 1);
        ack();
        chk("R8 cleared", req_o, 0);
        tick();
        chk("R8 stays clear", wake_o, 0);

        // R10 wake while masked
        irq_i[4] = 1; tick(); irq_i[4] = 0;
        core_mask_i = 5; tick();
        chk("R10 masked req", req_o, 0);
        chk("R10 masked wake", wake_o, 1);
        core_mask_i = 0; #1;
        chk("R5 unmasked req", req_o, 1);
        ack();

        // R5 top tier and software tier
        do_reset();
        core_mask_i = 5;
        dbg_i = 3'b001; tick(); dbg_i = 0; tick();
        chk("R5 debug masked", req_o, 0);
        exc_i = 4'b0100; tick(); exc_i = 0;
        chk("R5 unmaskable id", vec_id_o, 2);
        chk("R3 unmaskable lvl", lvl_o, 5);
        ack();
        core_mask_i = 4; #1;
        chk("R5 debug id", vec_id_o, 4);
        chk("R3 debug lvl", lvl_o, 5);
        ack();
        core_mask_i = 0;
        swlp_i = 1; tick(); swlp_i = 0;
        chk("R4 lp id", vec_id_o, 7);
        chk("R3 lp lvl", lvl_o, 1);
        core_mask_i = 1; #1;
        chk("R5 lp masked", req_o, 0);

        // R6 fast slot
        do_reset();
        wr(2'd0, 20, 16'h0004);
        wr(2'd0, 30, 16'h0006);
        wr(2'd1, 20, 16'h0ABC);
        irq_i[20] = 1; irq_i[30] = 1; tick();
        chk("R6 fast flag", fast_o, 1);
        chk("R6 fast id", vec_id_o, 28);
        chk("R6 fast addr", addr_o, 16'h0ABC);
        chk("R6 fast lvl", lvl_o, 2);
        dbg_i = 3'b001; tick(); dbg_i = 0;
        chk("R6 top beats fast id", vec_id_o, 4);
        chk("R6 top beats fast flag", fast_o, 0);
        ack();
        chk("R6 fast back", fast_o, 1);
        wr(2'd2, 0, 16'h0000);
        chk("R6 unmapped id", vec_id_o, 38);
        chk("R6 unmapped flag", fast_o, 0);
        chk("R7 base zero addr", addr_o, 16'h004C);

        finish_run();
    end
endmodule